// File: doc/BRIEF.md
# Alarm Match With Repeat Modes

This unit holds four alarm fields (seconds, minutes, hours, day of month), all in BCD. It compares them against the running time supplied by a separate clock counter. The comparison happens only on a once-per-second tick. When the enabled fields agree, the unit raises a one-cycle interrupt pulse on the cycle after that tick, provided that software has enabled the alarm interrupt.

Bit 7 of each alarm field is a repeat flag. Certain patterns of the four flags widen the alarm period by treating a field, and every field above it, as don't-care:

| Repeat flags set | Period | Fields compared |
|---|---|---|
| none | monthly | date, hour, minute, second |
| date only | daily | hour, minute, second |
| date and hour | hourly | minute, second |
| date, hour and minute | every minute | second |
| any other pattern | every second | none |

Software programs the unit through a byte-wide write port. A write that would put an out-of-range BCD value into an alarm field is dropped. The unit stays silent after reset until at least one alarm field has been written successfully. It has no read port: a test of register contents looks at when the interrupt fires.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset `irq_o` is 0, and no pulse is produced until at least one alarm-field write has been accepted, even when the time matches and the interrupt is enabled.
- R2: With all repeat flags clear (bit 7 of offsets 2..5), a tick fires only when date (bits 5:0), hours (bits 5:0), minutes (bits 6:0) and seconds (bits 6:0) all equal the current time.
- R3: With only the date repeat flag (offset 5, bit 7) set, the date is ignored, and hours, minutes and seconds must match.
- R4: With the date and hour repeat flags set (offsets 5 and 4, bit 7), only minutes and seconds must match.
- R5: With the date, hour and minute repeat flags set, only seconds must match.
- R6: Any other repeat-flag pattern, including all four set, fires on every tick.
- R7: A write to the seconds field (offset 2) or the minutes field (offset 3) is dropped, and the field left unchanged, when bits 6:0 decode as tens*10+units > 59.
- R8: A write to the hours field (offset 4) is dropped when bits 5:0 decode as tens*10+units > 23.
- R9: A write to the date field (offset 5) is dropped when bits 4:0 are zero.
- R10: `irq_o` can pulse only while bit 7 of the interrupt-control register (offset 6) is 1. Clearing that bit suppresses pulses that would otherwise occur.
- R11: A pulse lasts exactly one cycle. It appears in the cycle after the one in which `tick_i` is sampled high, and never without a tick.
- R12: Writes to offsets other than 2..6 change nothing in the alarm behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse, once per second |
| cur_sec_i | input | 8 | Current seconds, BCD |
| cur_min_i | input | 8 | Current minutes, BCD |
| cur_hour_i | input | 8 | Current hours, BCD |
| cur_date_i | input | 8 | Current day of month, BCD |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register offset |
| wr_data_i | input | 8 | Write data |
| irq_o | output | 1 | Alarm interrupt pulse |

## Verification
The bench builds the unit with its default parameters:

- a 3-bit offset,
- the alarm fields starting at offset 2,
- the interrupt-control register at offset 6,
- the enable at bit 7.

With these values every repeat-flag pattern in the period table can be set by writing single bytes. The offset range also leaves unused offsets 0, 1 and 7, which are used to show that stray writes have no effect. Range rejection is checked at the boundary codes 0x60, 0x5A, 0x24 and 0x20, and accepted hour 0x23 shows an in-range value taking effect.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NUM_FIELDS = 4;
  localparam int DATA_W     = 8;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DATE = 3;

  typedef enum logic [2:0] {
    MODE_MONTH,
    MODE_DAY,
    MODE_HOUR,
    MODE_MINUTE,
    MODE_SECOND
  } alarm_mode_e;

  typedef logic [NUM_FIELDS-1:0][DATA_W-1:0] field_vec_t;

  // bits that take part in the time comparison
  function automatic logic [DATA_W-1:0] field_mask(input int idx);
    case (idx)
      F_SEC, F_MIN: return 8'h7F;
      default:      return 8'h3F;
    endcase
  endfunction

  function automatic logic field_valid(input int idx, input logic [DATA_W-1:0] d);
    int unsigned v;
    case (idx)
      F_SEC, F_MIN: begin
        v = 32'(d[6:4]) * 10 + 32'(d[3:0]);
        return v <= 59;
      end
      F_HOUR: begin
        v = 32'(d[5:4]) * 10 + 32'(d[3:0]);
        return v <= 23;
      end
      default: return d[4:0] != 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int FIELD_OFS = 2,
  parameter int CTRL_OFS  = 6,
  parameter int IEN_BIT   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output field_vec_t        alarm_o,
  output logic              armed_o,
  output logic              irq_en_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

  logic [NUM_FIELDS-1:0] accept;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    localparam logic [ADDR_W-1:0] FA = ADDR_W'(FIELD_OFS + f);
    logic hit, ok;
    assign hit       = wr_en_i && (wr_addr_i == FA);
    assign ok        = field_valid(f, wr_data_i);
    assign accept[f] = hit && ok;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        alarm_o[f] <= '0;
      else if (accept[f]) alarm_o[f] <= wr_data_i;
    end

    // covers R7, R8 and R9 for the respective field
    p_reject_keeps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && !ok) |=> $stable(alarm_o[f]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o  <= 1'b0;
      irq_en_o <= 1'b0;
    end else begin
      if (|accept) armed_o <= 1'b1;
      if (wr_en_i && wr_addr_i == CTRL_A) irq_en_o <= wr_data_i[IEN_BIT];
    end
  end

  p_armed_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |=> armed_o);
endmodule

// File: rtl/alarm_mode_dec.sv
module alarm_mode_dec
  import alarm_pkg::*;
(
  input  logic [NUM_FIELDS-1:0] rpt_i,
  output alarm_mode_e           mode_o,
  output logic [NUM_FIELDS-1:0] care_o
);
  // rpt_i index: 0 sec, 1 min, 2 hour, 3 date
  always_comb begin
    case (rpt_i)
      4'b0000: begin mode_o = MODE_MONTH;  care_o = 4'b1111; end
      4'b1000: begin mode_o = MODE_DAY;    care_o = 4'b0111; end
      4'b1100: begin mode_o = MODE_HOUR;   care_o = 4'b0011; end
      4'b1110: begin mode_o = MODE_MINUTE; care_o = 4'b0001; end
      default: begin mode_o = MODE_SECOND; care_o = 4'b0000; end
    endcase
  end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alarm_pkg::*;
(
  input  field_vec_t            alarm_i,
  input  field_vec_t            cur_i,
  input  logic [NUM_FIELDS-1:0] care_i,
  output logic                  match_o
);
  logic [NUM_FIELDS-1:0] eq;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_eq
    localparam logic [DATA_W-1:0] M = field_mask(f);
    assign eq[f] = !care_i[f] || ((alarm_i[f] & M) == (cur_i[f] & M));
  end

  assign match_o = &eq;
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int FIELD_OFS = 2,
  parameter int CTRL_OFS  = 6,
  parameter int IEN_BIT   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [7:0]        cur_sec_i,
  input  logic [7:0]        cur_min_i,
  input  logic [7:0]        cur_hour_i,
  input  logic [7:0]        cur_date_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              irq_o
);
  field_vec_t            alarm, cur;
  logic                  armed, irq_en, match;
  logic [NUM_FIELDS-1:0] rpt, care;
  alarm_mode_e           mode;
  logic                  irq_q;

  assign cur = {cur_date_i, cur_hour_i, cur_min_i, cur_sec_i};

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_rpt
    assign rpt[f] = alarm[f][DATA_W-1];
  end

  alarm_regs #(
    .ADDR_W(ADDR_W), .FIELD_OFS(FIELD_OFS), .CTRL_OFS(CTRL_OFS), .IEN_BIT(IEN_BIT)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .alarm_o(alarm), .armed_o(armed), .irq_en_o(irq_en)
  );

  alarm_mode_dec u_dec (.rpt_i(rpt), .mode_o(mode), .care_o(care));

  alarm_cmp u_cmp (.alarm_i(alarm), .cur_i(cur), .care_i(care), .match_o(match));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= tick_i && armed && irq_en && match;
  end

  assign irq_o = irq_q;

  p_irq_after_tick_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(tick_i));
  p_irq_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(irq_en));
  p_irq_armed_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(armed));
  p_second_mode_fires_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && armed && irq_en && mode == MODE_SECOND) |=> irq_o);
  p_care_thermo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(NUM_FIELDS'(care + 1'b1)));
endmodule

// File: tb/alarm_match_unit_test.sv
module alarm_match_unit_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [7:0] cur_sec_i = '0, cur_min_i = '0, cur_hour_i = '0, cur_date_i = '0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit        exp_q[$];
  string     tag_q[$];

  always #5 clk_i = ~clk_i;

  alarm_match_unit uut (.*);

  task automatic report(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: irq_o=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic tick(input logic [7:0] d, h, m, s, input bit exp, input string tag);
    @(negedge clk_i);
    cur_date_i = d; cur_hour_i = h; cur_min_i = m; cur_sec_i = s;
    tick_i = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  // monitor: every cycle, compare irq_o against queue (tick) or 0 (no tick)
  initial begin
    forever begin
      bit t;
      @(posedge clk_i);
      t = tick_i && rst_ni;
      @(negedge clk_i);
      if (t) begin
        report(tag_q.pop_front(), irq_o, exp_q.pop_front());
      end else if (rst_ni && irq_o !== 1'b0) begin
        report("R11 stray pulse", irq_o, 1'b0);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    report("R1 reset", irq_o, 1'b0);
    rst_ni = 1'b1;
    wr(3'd6, 8'h80);
    tick(8'h00, 8'h00, 8'h00, 8'h00, 1'b0, "R1 unarmed");
    // monthly
    wr(3'd2, 8'h30); wr(3'd3, 8'h15); wr(3'd4, 8'h08); wr(3'd5, 8'h12);
    tick(8'h12, 8'h08, 8'h15, 8'h30, 1'b1, "R2 full match");
    tick(8'h13, 8'h08, 8'h15, 8'h30, 1'b0, "R2 date differs");
    tick(8'h12, 8'h08, 8'h15, 8'h31, 1'b0, "R2 sec differs");
    tick(8'h12, 8'h09, 8'h15, 8'h30, 1'b0, "R2 hour differs");
    // daily
    wr(3'd5, 8'h92);
    tick(8'h13, 8'h08, 8'h15, 8'h30, 1'b1, "R3 date ignored");
    tick(8'h13, 8'h08, 8'h16, 8'h30, 1'b0, "R3 min differs");
    // hourly
    wr(3'd4, 8'h88);
    tick(8'h01, 8'h23, 8'h15, 8'h30, 1'b1, "R4 hour ignored");
    tick(8'h01, 8'h23, 8'h16, 8'h30, 1'b0, "R4 min differs");
    // every minute
    wr(3'd3, 8'h95);
    tick(8'h01, 8'h23, 8'h44, 8'h30, 1'b1, "R5 min ignored");
    tick(8'h01, 8'h23, 8'h44, 8'h31, 1'b0, "R5 sec differs");
    // every second
    wr(3'd2, 8'hB0);
    tick(8'h07, 8'h02, 8'h03, 8'h04, 1'b1, "R6 all flags");
    wr(3'd5, 8'h12);
    tick(8'h07, 8'h02, 8'h03, 8'h05, 1'b1, "R6 odd pattern");
    // back to monthly
    wr(3'd2, 8'h30); wr(3'd3, 8'h15); wr(3'd4, 8'h08); wr(3'd5, 8'h12);
    wr(3'd2, 8'h60);
    tick(8'h12, 8'h08, 8'h15, 8'h30, 1'b1, "R7 sec 60 dropped");
    wr(3'd3, 8'h5A);
    tick(8'h12, 8'h08, 8'h15, 8'h30, 1'b1, "R7 min 5A dropped");
    wr(3'd4, 8'h24);
    tick(8'h12, 8'h08, 8'h15, 8'h30, 1'b1, "R8 hour 24 dropped");
    wr(3'd4, 8'h23);
    tick(8'h12, 8'h08, 8'h15, 8'h30, 1'b0, "R8 hour 23 taken");
    tick(8'h12, 8'h23, 8'h15, 8'h30, 1'b1, "R8 hour 23 match");
    wr(3'd4, 8'h08);
    wr(3'd5, 8'h20);
    tick(8'h12, 8'h08, 8'h15, 8'h30, 1'b1, "R9 date 20 dropped");
    wr(3'd5, 8'h00);
    tick(8'h12, 8'h08, 8'h15, 8'h30, 1'b1, "R9 date 00 dropped");
    // enable gating
    wr(3'd6, 8'h7F);
    tick(8'h12, 8'h08, 8'h15, 8'h30, 1'b0, "R10 disabled");
    wr(3'd6, 8'h80);
    tick(8'h12, 8'h08, 8'h15, 8'h30, 1'b1, "R10 re-enabled");
    // unused offsets
    wr(3'd0, 8'hFF); wr(3'd1, 8'h80); wr(3'd7, 8'h00);
    tick(8'h12, 8'h08, 8'h15, 8'h30, 1'b1, "R12 match kept");
    tick(8'h12, 8'h08, 8'h15, 8'h29, 1'b0, "R12 mismatch kept");
    // back-to-back idle: pulse must have ended (R11 via monitor)
    repeat (4) @(negedge clk_i);
    report("R11 idle low", irq_o, 1'b0);
    finish_run();
  end
endmodule